// File: doc/BRIEF.md
# Stepper Motor Step Sequencer

This block sequences the phase pattern of a stepper motor under processor control. Software writes the interval until the next step into a buffer register. A 16-bit down-counter, which advances only on a stepping-clock strobe, works through that interval. When the count runs out, the block advances the phase pattern, emits a one-cycle step pulse, reloads the counter from the buffer and raises a sticky interrupt. The interrupt tells software to put the following interval into the buffer. An acceleration or deceleration ramp is therefore played out one interval per interrupt.

A mode bit chooses between two uses of the block. With the bit set, the block is a general-purpose output: the pattern register is written directly and the counter stays cleared. Clearing the bit starts stepping. At that moment the first interval is loaded and an interrupt is raised, but no step is taken. A separate control bit drives the motor power-control output directly.

Register map on the write bus (`wr_addr`): 0 mode (bit 0 = general-purpose output mode, reset 1); 1 step control (bit 0 = step enable, bit 4 = power control); 2 phase pattern (bits 7:0); 3 interval buffer (bits 15:0); 4 status (writing 1 to bit 0 clears the interrupt).

Top module: `step_seq`

## Requirements
- R1: A write to address 2 updates the phase pattern only while mode bit 0 is 1. While stepping (mode bit 0 is 0), such writes leave the pattern unchanged.
- R2: A write that changes mode bit 0 from 1 to 0 loads the counter from the interval buffer and sets the interrupt on the following edge, and produces no step pulse for this load.
- R3: While stepping, a strobe that arrives with the counter at 1 or 0 is an expiry. On that edge the counter reloads from the interval buffer and the interrupt is set. If step enable is 1, `step_pulse` is high for exactly the following cycle.
- R4: The counter decrements only on `step_tick`, so a loaded interval of N produces an expiry on the N-th strobe after the load.
- R5: A write that changes mode bit 0 from 0 to 1 clears the counter. No step pulse, advance or reload follows from that cycle onward, even if a strobe arrives in the same cycle.
- R6: Step enable (address 1, bit 0) gates only the pattern advance and the step pulse. An expiry with step enable 0 still reloads and interrupts. `phase_out` always shows the pattern register.
- R7: Each advance rotates the 8-bit pattern left by one position, with bit 7 moving into bit 0.
- R8: `pwr_out` follows address 1 bit 4 from the edge after the write.
- R9: The interrupt stays set until software writes 1 to address 4 bit 0. If a reload sets it in the same cycle as the clear, the set wins.
- R10: A write to the interval buffer does not disturb a running count. An expiry in the same cycle as a buffer write reloads the value the buffer held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| step_tick | input | 1 | Stepping-clock strobe, one system cycle wide |
| phase_out | output | 8 | Motor phase pattern |
| step_pulse | output | 1 | One-cycle pulse per pattern advance |
| irq | output | 1 | Sticky interval-request interrupt |
| pwr_out | output | 1 | Motor power-control output |

## Verification
Two pairs of events can land in the same cycle. An interrupt clear can meet the reload that sets the interrupt, and a buffer write can meet an expiry that reads the buffer. Both are provoked by loading an interval of 1 and strobing every cycle, so that every strobe cycle is an expiry, and then writing the status clear or a new interval on consecutive cycles. The bench's reference model decides the outcome: the interrupt stays set, and the step spacing follows the old buffer value first. Every output is compared against the model on every clock.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    typedef enum logic [2:0] {
        ADDR_MODE  = 3'd0,
        ADDR_CTRL  = 3'd1,
        ADDR_PAT   = 3'd2,
        ADDR_IVL   = 3'd3,
        ADDR_STAT  = 3'd4
    } reg_addr_e;

    localparam int MODE_GPO_BIT = 0;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PWR_BIT = 4;
    localparam int STAT_IRQ_BIT = 0;

    typedef struct packed {
        logic gpo;
        logic step_en;
        logic pwr;
    } mode_s;

    typedef struct packed {
        logic start;
        logic stop;
    } evt_s;

    function automatic logic count_done(input logic [15:0] cnt);
        return (cnt <= 16'd1);
    endfunction

endpackage

// File: rtl/step_regs.sv
module step_regs
    import step_seq_pkg::*;
#(
    parameter int PW = 8,
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          expire,
    output mode_s         mode,
    output evt_s          evt,
    output logic [PW-1:0] pat,
    output logic [TW-1:0] ivl,
    output logic          irq
);

    mode_s         mode_q;
    logic [PW-1:0] pat_q;
    logic [TW-1:0] ivl_q;
    logic          irq_q;
    logic          wr_mode, wr_ctrl, wr_pat, wr_ivl, wr_stat;
    logic          advance;

    always_comb begin
        wr_mode = wr_en && (wr_addr == ADDR_MODE);
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_pat  = wr_en && (wr_addr == ADDR_PAT);
        wr_ivl  = wr_en && (wr_addr == ADDR_IVL);
        wr_stat = wr_en && (wr_addr == ADDR_STAT);
        evt.start = wr_mode && !wr_data[MODE_GPO_BIT] && mode_q.gpo;
        evt.stop  = wr_mode &&  wr_data[MODE_GPO_BIT] && !mode_q.gpo;
        advance   = expire && mode_q.step_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{gpo: 1'b1, step_en: 1'b0, pwr: 1'b0};
            pat_q  <= '0;
            ivl_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_mode)
                mode_q.gpo <= wr_data[MODE_GPO_BIT];
            if (wr_ctrl) begin
                mode_q.step_en <= wr_data[CTRL_EN_BIT];
                mode_q.pwr     <= wr_data[CTRL_PWR_BIT];
            end
            if (wr_ivl)
                ivl_q <= wr_data[TW-1:0];
            if (wr_pat && mode_q.gpo)
                pat_q <= wr_data[PW-1:0];
            else if (advance)
                pat_q <= {pat_q[PW-2:0], pat_q[PW-1]};
            if (evt.start || expire)
                irq_q <= 1'b1;
            else if (wr_stat && wr_data[STAT_IRQ_BIT])
                irq_q <= 1'b0;
        end
    end

    assign mode = mode_q;
    assign pat  = pat_q;
    assign ivl  = ivl_q;
    assign irq  = irq_q;

    // R1
    pat_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.gpo && !$past(mode_q.gpo) && !$past(expire)) |-> $stable(pat_q));

    // R9
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (expire || evt.start) |=> irq_q);

endmodule

// File: rtl/step_timer.sv
module step_timer
    import step_seq_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          active,
    input  logic          step_en,
    input  evt_s          evt,
    input  logic [TW-1:0] ivl,
    output logic          expire,
    output logic          step_pulse
);

    logic [TW-1:0] cnt_q;
    logic          pulse_q;

    always_comb
        expire = active && !evt.stop && tick && count_done(16'(cnt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire && step_en;
            if (evt.start || expire)
                cnt_q <= ivl;
            else if (evt.stop || !active)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign step_pulse = pulse_q;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(evt.start) |-> (cnt_q == $past(ivl)) && !pulse_q);

    // R5
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(evt.stop) |-> (cnt_q == '0) && !pulse_q);

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && !$past(tick) && !$past(evt.start) && !$past(evt.stop))
            |-> $stable(cnt_q));

    // R3
    pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(active) && $past(tick) && $past(step_en));

endmodule

// File: rtl/step_seq.sv
module step_seq
    import step_seq_pkg::*;
#(
    parameter int PW = 8,
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          step_tick,
    output logic [PW-1:0] phase_out,
    output logic          step_pulse,
    output logic          irq,
    output logic          pwr_out
);

    mode_s         mode;
    evt_s          evt;
    logic [TW-1:0] ivl;
    logic          expire;

    step_regs #(.PW(PW), .DW(DW), .TW(TW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .expire  (expire),
        .mode    (mode),
        .evt     (evt),
        .pat     (phase_out),
        .ivl     (ivl),
        .irq     (irq)
    );

    step_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (step_tick),
        .active     (!mode.gpo),
        .step_en    (mode.step_en),
        .evt        (evt),
        .ivl        (ivl),
        .expire     (expire),
        .step_pulse (step_pulse)
    );

    assign pwr_out = mode.pwr;

    // R7
    rotate_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> phase_out == {$past(phase_out[PW-2:0]), $past(phase_out[PW-1])});

    // R6
    no_advance_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(mode.step_en) && !$past(mode.gpo)) |-> $stable(phase_out) && !step_pulse);

endmodule

// File: tb/step_seq_test.sv
module step_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        step_tick = 1'b0;
    logic [7:0]  phase_out;
    logic        step_pulse, irq, pwr_out;

    always #2 clk = ~clk;

    step_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .step_tick(step_tick), .phase_out(phase_out), .step_pulse(step_pulse),
        .irq(irq), .pwr_out(pwr_out)
    );

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string req = "R0";
    bit    started = 0;

    // behavioural reference model
    bit       m_gpo = 1, m_en = 0, m_pwr = 0, m_irq = 0, m_pulse = 0;
    bit [7:0] m_pat = 0;
    int       m_buf = 0, m_cnt = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_gpo = 1; m_en = 0; m_pwr = 0; m_irq = 0; m_pulse = 0;
            m_pat = 0; m_buf = 0; m_cnt = 0;
        end else begin
            bit start, stop, exp;
            bit [7:0] npat;
            start = wr_en && wr_addr == 0 && !wr_data[0] && m_gpo;
            stop  = wr_en && wr_addr == 0 &&  wr_data[0] && !m_gpo;
            exp   = !m_gpo && !stop && step_tick && m_cnt <= 1;
            npat  = m_pat;
            if (wr_en && wr_addr == 2 && m_gpo) npat = wr_data[7:0];
            else if (exp && m_en) npat = {m_pat[6:0], m_pat[7]};
            m_pulse = exp && m_en;
            if (start || exp) m_irq = 1;
            else if (wr_en && wr_addr == 4 && wr_data[0]) m_irq = 0;
            if (start || exp) m_cnt = m_buf;
            else if (stop || m_gpo) m_cnt = 0;
            else if (step_tick) m_cnt = m_cnt - 1;
            m_pat = npat;
            if (wr_en && wr_addr == 3) m_buf = wr_data;
            if (wr_en && wr_addr == 1) begin m_en = wr_data[0]; m_pwr = wr_data[4]; end
            if (wr_en && wr_addr == 0) m_gpo = wr_data[0];
        end
        started = 1;
    end

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(req, "phase_out", phase_out, m_pat);
            chk(req, "step_pulse", step_pulse, m_pulse);
            chk(req, "irq", irq, m_irq);
            chk(req, "pwr_out", pwr_out, m_pwr);
        end
    end

    task automatic cyc(bit we, int a, int d, bit t);
        @(negedge clk);
        wr_en = we; wr_addr = 3'(a); wr_data = 16'(d); step_tick = t;
        @(posedge clk);
    endtask

    task automatic idle(int n, int tick_every);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, (i % tick_every) == 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        req = "R0_reset";
        chk("R0_reset", "phase_out", phase_out, 0);
        chk("R0_reset", "irq", irq, 0);
        chk("R0_reset", "step_pulse", step_pulse, 0);
        // R1 pattern write in output mode, R8 power bit
        req = "R1"; cyc(1, 2, 'h11, 0); idle(2, 100);
        chk("R1", "gpo write", phase_out, 'h11);
        req = "R8"; cyc(1, 1, 'h11, 0); idle(1, 100);
        chk("R8", "pwr_out", pwr_out, 1);
        // R2 start: load, irq, no pulse
        req = "R2"; cyc(1, 3, 3, 0); cyc(1, 0, 0, 1); idle(1, 100);
        chk("R2", "irq after start", irq, 1);
        // R1 writes ignored while stepping
        req = "R1"; cyc(1, 2, 'hFF, 0); idle(1, 100);
        chk("R1", "locked pattern", phase_out, 'h11);
        // R3 R4 R7 expiries with sparse ticks
        req = "R4"; cyc(1, 4, 1, 0); idle(40, 2);
        req = "R7"; idle(30, 3);
        // R9 clear coincident with expiry; R10 buffer write coincident
        req = "R9"; cyc(1, 3, 1, 0); idle(8, 1);
        for (int i = 0; i < 6; i++) cyc(1, 4, 1, 1);
        req = "R10"; cyc(1, 3, 5, 1); cyc(1, 3, 2, 1); idle(20, 1);
        // R6 step enable off
        req = "R6"; cyc(1, 1, 'h10, 0); idle(20, 1);
        cyc(1, 1, 'h01, 0); idle(10, 1);
        // R5 stop with simultaneous tick
        req = "R5"; cyc(1, 3, 1, 0); idle(3, 1); cyc(1, 0, 1, 1); idle(10, 1);
        chk("R5", "no pulse after stop", step_pulse, 0);
        // mixed traffic
        req = "R3";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 16;
            int a = $urandom % 5;
            int d = (a == 3) ? ($urandom % 6) : (a == 0 ? (($urandom % 4) == 0) : $urandom);
            if (a == 0 && r > 2) cyc(0, 0, 0, ($urandom % 3) == 0);
            else cyc(r < 5, a, d, ($urandom % 3) == 0);
        end
        idle(5, 1);
        finish_run();
    end

    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
    end

endmodule